// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block sits behind a bus transceiver that has been put into its low-power standby state. It samples a bus-level input that has already been thresholded into dominant or recessive. It looks for a three-phase sequence on that input: dominant, then recessive, then dominant. Each phase has a minimum length, and the whole sequence must finish inside one overall time window. Because of these rules, a bus that is stuck dominant, for example through a short, can never wake the system.

Once the sequence is seen, the block raises a wake flag and starts toggling its receive-data output so that the output follows the bus level. Dominant gives a low output and recessive gives a high output. The output passes through a selectable delay of a few clock cycles. This lasts until the controller leaves standby. The filter lengths, the window length and the output delay are all given as clock-cycle counts on input ports.

Top module: `wake_pattern_det`

## Requirements
- R1: While reset is asserted, and directly after it, `wake_o` is 0 and `rxd_o` is 1.
- R2: `wake_o` rises only after this sequence of bus samples taken at rising clock edges:
  - more than `flt1_cyc_i` dominant samples, starting on a recessive-to-dominant transition;
  - then more than `flt2_cyc_i` recessive samples;
  - then `flt2_cyc_i`+1 dominant samples.
  `wake_o` is 1 directly after the edge that takes the last of these samples.
- R3: A phase that ends before its minimum length returns the detector to idle. The sample that ends that phase does not arm a new attempt. Only a later recessive-to-dominant transition re-arms the detector.
- R4: The arming edge counts as window index 0. A wake-up is reported only if it completes on an edge with index below `tmo_cyc_i`. At the edge with index `tmo_cyc_i`, an incomplete attempt is dropped back to idle.
- R5: A bus held dominant never produces a wake-up, whatever its duration, and also when it has been dominant since reset.
- R6: While `wake_o` is 0, `rxd_o` is 1.
- R7: While `wake_o` is 1, `rxd_o` is the inverse of the bus sample taken `dly_cyc_i` edges earlier. With a delay of 0, that is the sample taken at the most recent edge. Delays above `DLY_MAX` are clamped to `DLY_MAX`.
- R8: When `standby_i` is 0 at a rising edge, the wake flag and all pattern progress are cleared at that edge, and no pattern is detected while `standby_i` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | 1 while the transceiver is in standby |
| bus_dom_i | input | 1 | Sampled bus level: 1 = dominant, 0 = recessive |
| flt1_cyc_i | input | FLT_W | Minimum length of the first dominant phase, in cycles (must be exceeded) |
| flt2_cyc_i | input | FLT_W | Minimum length of the recessive phase and the second dominant phase, in cycles |
| tmo_cyc_i | input | TMO_W | Overall window length, in cycles |
| dly_cyc_i | input | DLY_W | Delay from bus to `rxd_o` while toggling, in cycles |
| rxd_o | output | 1 | Receive data: 1 until a wake-up, then the inverted, delayed bus level |
| wake_o | output | 1 | Wake-up detected flag |

## Verification
The assertions make four assumptions about the inputs:
- the filter, window and delay counts do not change during a detection attempt;
- the window count is at least 1;
- `bus_dom_i` is already synchronous to `clk_i`;
- `standby_i` is the only thing that clears a completed wake-up.

If the window count could change while the timer is running, the bound on the window counter could be exceeded. The stimulus respects these assumptions. It programs the counts once, changes the delay only while a wake-up is held, and changes `bus_dom_i` and `standby_i` only on falling clock edges.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DOM1,
    ST_REC2,
    ST_DOM3,
    ST_WAKE
  } wk_state_e;
endpackage

// File: rtl/wake_window.sv
module wake_window #(
  parameter int TMO_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] tmo_cyc_i,
  output logic             expired_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (arm_i)         cnt_q <= TMO_W'(1);
    else if (run_i)         cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    else                    cnt_q <= '0;
  end

  assign expired_o = run_i && (cnt_q >= tmo_cyc_i);

  // R4
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= tmo_cyc_i);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_pkg::*;
#(
  parameter int FLT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             bus_dom_i,
  input  logic [FLT_W-1:0] flt1_cyc_i,
  input  logic [FLT_W-1:0] flt2_cyc_i,
  input  logic             expired_i,
  output logic             arm_o,
  output logic             run_o,
  output logic             wake_o
);
  localparam logic [FLT_W-1:0] CNT_MAX = {FLT_W{1'b1}};

  wk_state_e        st_q, st_d;
  logic [FLT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             bus_q;
  logic             rise;

  assign rise    = bus_dom_i && !bus_q;
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign run_o   = (st_q == ST_DOM1) || (st_q == ST_REC2) || (st_q == ST_DOM3);
  assign arm_o   = standby_i && (st_q == ST_IDLE) && rise;
  assign wake_o  = (st_q == ST_WAKE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!standby_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rise) begin
            st_d  = ST_DOM1;
            cnt_d = FLT_W'(1);
          end
        end
        ST_DOM1: begin
          if (expired_i) begin
            st_d = ST_IDLE; cnt_d = '0;
          end else if (bus_dom_i) begin
            cnt_d = cnt_inc;
          end else if (cnt_q > flt1_cyc_i) begin
            st_d = ST_REC2; cnt_d = FLT_W'(1);
          end else begin
            st_d = ST_IDLE; cnt_d = '0;
          end
        end
        ST_REC2: begin
          if (expired_i) begin
            st_d = ST_IDLE; cnt_d = '0;
          end else if (!bus_dom_i) begin
            cnt_d = cnt_inc;
          end else if (cnt_q > flt2_cyc_i) begin
            st_d = ST_DOM3; cnt_d = FLT_W'(1);
          end else begin
            st_d = ST_IDLE; cnt_d = '0;
          end
        end
        ST_DOM3: begin
          if (expired_i || !bus_dom_i) begin
            st_d = ST_IDLE; cnt_d = '0;
          end else if (cnt_q >= flt2_cyc_i) begin
            st_d = ST_WAKE; cnt_d = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        ST_WAKE: ;
        default: begin
          st_d = ST_IDLE; cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bus_q <= 1'b1;  // treat the bus as dominant at reset so a stuck bus never arms
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bus_q <= bus_dom_i;
    end
  end

  // R8
  leave_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_i |=> st_q == ST_IDLE);
  // R5
  stuck_dom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && bus_q && bus_dom_i) |=> st_q == ST_IDLE);
  // R2
  wake_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> ($past(st_q) == ST_DOM3) && $past(bus_dom_i));
  // R4
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && expired_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/rx_delay.sv
module rx_delay #(
  parameter int DLY_W   = 4,
  parameter int DLY_MAX = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_dom_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             wake_i,
  output logic             rxd_o
);
  logic [DLY_MAX:0] hist_q;
  logic [DLY_W-1:0] sel;
  logic             tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q[0] <= 1'b0;
    else         hist_q[0] <= bus_dom_i;
  end

  for (genvar g = 1; g <= DLY_MAX; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= 1'b0;
      else         hist_q[g] <= hist_q[g-1];
    end
  end

  assign sel = (dly_i > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : dly_i;

  always_comb begin
    tap = hist_q[0];
    for (int i = 0; i <= DLY_MAX; i++) begin
      if (sel == DLY_W'(i)) tap = hist_q[i];
    end
  end

  assign rxd_o = wake_i ? ~tap : 1'b1;

  // R7
  zero_dly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && dly_i == '0) |-> rxd_o == !$past(bus_dom_i));
endmodule

// File: rtl/wake_pattern_det.sv
module wake_pattern_det #(
  parameter int FLT_W   = 16,
  parameter int TMO_W   = 20,
  parameter int DLY_W   = 4,
  parameter int DLY_MAX = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             bus_dom_i,
  input  logic [FLT_W-1:0] flt1_cyc_i,
  input  logic [FLT_W-1:0] flt2_cyc_i,
  input  logic [TMO_W-1:0] tmo_cyc_i,
  input  logic [DLY_W-1:0] dly_cyc_i,
  output logic             rxd_o,
  output logic             wake_o
);
  logic arm, run, expired;

  wake_seq #(.FLT_W(FLT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .standby_i  (standby_i),
    .bus_dom_i  (bus_dom_i),
    .flt1_cyc_i (flt1_cyc_i),
    .flt2_cyc_i (flt2_cyc_i),
    .expired_i  (expired),
    .arm_o      (arm),
    .run_o      (run),
    .wake_o     (wake_o)
  );

  wake_window #(.TMO_W(TMO_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .run_i     (run),
    .tmo_cyc_i (tmo_cyc_i),
    .expired_o (expired)
  );

  rx_delay #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_dom_i (bus_dom_i),
    .dly_i     (dly_cyc_i),
    .wake_i    (wake_o),
    .rxd_o     (rxd_o)
  );

  // R6
  rxd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_o |-> rxd_o);
  // R1
  reset_val_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!wake_o && rxd_o));
endmodule

// File: tb/tb_wake_pattern_det.sv
module tb_wake_pattern_det;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {first dominant, recessive, second dominant, expected wake} with flt1=4, flt2=2, window=30
  localparam int VEC [NVEC][4] = '{
    '{5, 3, 3, 1},
    '{4, 3, 3, 0},
    '{5, 2, 3, 0},
    '{5, 3, 2, 0},
    '{10, 10, 5, 1},
    '{15, 14, 3, 0},
    '{14, 13, 3, 1},
    '{15, 13, 3, 0},
    '{8, 4, 6, 1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        standby = 1'b1;
  logic        bus_dom = 1'b0;
  logic [15:0] flt1 = 16'd4;
  logic [15:0] flt2 = 16'd2;
  logic [19:0] tmo = 20'd30;
  logic [3:0]  dly = 4'd0;
  logic        rxd, wake;
  int          n_vec = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_pattern_det dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .standby_i  (standby),
    .bus_dom_i  (bus_dom),
    .flt1_cyc_i (flt1),
    .flt2_cyc_i (flt2),
    .tmo_cyc_i  (tmo),
    .dly_cyc_i  (dly),
    .rxd_o      (rxd),
    .wake_o     (wake)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold(input logic d, input int n);
    bus_dom = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic pattern(input int n1, input int n2, input int n3);
    hold(1'b0, 3);
    hold(1'b1, n1);
    hold(1'b0, n2);
    hold(1'b1, n3);
  endtask

  task automatic clear();
    standby = 1'b0;
    hold(1'b0, 2);
    standby = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check("R1 wake in reset", wake, 1'b0);
    check("R1 rxd in reset", rxd, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 wake after reset", wake, 1'b0);
    check("R1 rxd after reset", rxd, 1'b1);

    // table walk: R2 phase lengths, R3 short phases, R4 window edges
    for (int i = 0; i < NVEC; i++) begin
      pattern(VEC[i][0], VEC[i][1], VEC[i][2]);
      check($sformatf("R2/R4 vec%0d wake", i), wake, VEC[i][3] != 0);
      check($sformatf("R6/R7 vec%0d rxd", i), rxd, VEC[i][3] == 0);
      clear();
    end

    // R7 toggling with zero delay
    pattern(5, 3, 3);
    check("R7 woken", wake, 1'b1);
    hold(1'b0, 1);
    check("R7 rxd follows recessive", rxd, 1'b1);
    hold(1'b1, 1);
    check("R7 rxd follows dominant", rxd, 1'b0);
    hold(1'b0, 1);
    check("R7 wake held while toggling", wake, 1'b1);

    // R7 delayed toggling
    dly = 4'd3;
    hold(1'b1, 5);
    check("R7 delayed dominant", rxd, 1'b0);
    hold(1'b0, 3);
    check("R7 delay not yet elapsed", rxd, 1'b0);
    hold(1'b0, 1);
    check("R7 delay elapsed", rxd, 1'b1);
    dly = 4'd0;

    // R8 leaving standby clears
    standby = 1'b0;
    @(negedge clk);
    check("R8 wake cleared", wake, 1'b0);
    check("R8 rxd high", rxd, 1'b1);
    pattern(5, 3, 3);
    check("R8 no detection outside standby", wake, 1'b0);
    standby = 1'b1;
    hold(1'b0, 2);

    // R5 stuck dominant
    hold(1'b0, 3);
    hold(1'b1, 100);
    check("R5 stuck dominant no wake", wake, 1'b0);
    check("R5 rxd high", rxd, 1'b1);
    clear();

    // R3 the edge ending a short phase does not arm
    hold(1'b0, 3);
    hold(1'b1, 5);
    hold(1'b0, 1);
    hold(1'b1, 5);
    hold(1'b0, 3);
    hold(1'b1, 3);
    check("R3 consumed edge no arm", wake, 1'b0);
    clear();
    pattern(5, 3, 3);
    check("R3 re-armed on new edge", wake, 1'b1);
    clear();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule